// File: doc/BRIEF.md
# Four-Channel Clock Skew Equalizer

This block works out how much extra delay each of four remote clock channels needs so that all of them arrive at the same time. Each channel supplies a round-trip delay count taken from a time-to-digital converter, where one count is about 13 ps. A start pulse takes a snapshot of all four counts. The block then sorts them in ascending order and keeps the channel number attached to each value. It takes the gaps between neighbouring sorted values and adds those gaps up from each sorted position to the top of the order. The slowest channel is the reference and gets no added delay. Each sum is halved to give a one-way figure, and the result is written back to the lane of the channel it came from.

The lanes feed per-channel programmable delay lines. Control is a plain start/busy/done handshake. No data stream enters or leaves the block, so there is no valid/ready port and no back-pressure. The start input is sampled only while the block is idle. The results stay unchanged between completions, so a downstream register can pick them up whenever it needs them.

Top module: `skew_comp_top`

## Requirements
- R1: While reset is low, `busy` and `done` are 0, every adjustment lane is 0 and `ref_ch` is 0.
- R2: A start seen while idle captures all four `rtt_in` lanes. Any change to `rtt_in` after that edge has no effect on the result of that run.
- R3: Take the edge that accepts start as edge 0. `busy` is 1 after edge 0 and after edge 1. After edge 2, `busy` is 0 and `done` is 1, and `done` lasts exactly one cycle. `busy` and `done` are never 1 at the same time.
- R4: A start that arrives while `busy` is 1 is ignored. It neither restarts the run nor changes the result.
- R5: The adjustment of channel c equals (Dmax − Dc) >> 1, where Dmax is the largest captured count. The bit shifted out is dropped.
- R6: The reference channel holds a largest count and gets adjustment 0. `ref_ch` reports its number. When several channels share the maximum, the one with the highest channel number is the reference, because ties sort with the lower channel number first.
- R7: Channels with equal captured counts get equal adjustments.
- R8: The adjustment of channel c appears in `adj_out[16c+15:16c]` and `rtt_in[16c+15:16c]` is channel c's input. It goes to the channel's own lane, not to the lane of its sorted position.
- R9: `adj_out` and `ref_ch` change only on the edge that raises `done`. They hold their values in every other cycle.
- R10: Counts anywhere in 0..65535 give correct 16-bit results without overflow. For example, a 0 next to a 65535 gives 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a computation; taken only when idle |
| rtt_in | input | 64 | Four round-trip counts, channel c at bits 16c+15:16c |
| busy | output | 1 | High while a computation is in progress |
| done | output | 1 | One-cycle pulse when new results are loaded |
| adj_out | output | 64 | Four one-way delay codes, channel c at bits 16c+15:16c |
| ref_ch | output | 2 | Number of the reference (zero-adjustment) channel |

## Verification
The assertions assume that start is a synchronous level sampled at the clock edge. They also assume that reset is held long enough for the control state to settle to idle. Beyond that they place no limit on the counts, because any 16-bit value is legal. The stimulus drives start and `rtt_in` only at the falling edge. It deliberately pulses start and rewrites `rtt_in` while `busy` is high, and it covers ties, all-equal inputs, extreme values and odd differences. A behavioural model in the bench is compared against the outputs on every cycle.

// File: rtl/skew_pkg.sv
package skew_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SORT = 2'd1,
    ST_CALC = 2'd2
  } ctl_state_t;
endpackage

// File: rtl/skew_sorter.sv
// Combinational odd-even transposition sort carrying the channel number.
// Order key is {value, channel}, so ties keep lower channel first.
module skew_sorter #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [DW-1:0] val_in  [NCH],
  output logic [DW-1:0] val_out [NCH],
  output logic [IW-1:0] idx_out [NCH]
);
  logic [DW-1:0] wv [NCH];
  logic [IW-1:0] wi [NCH];
  logic [DW-1:0] tv;
  logic [IW-1:0] ti;

  always_comb begin
    tv = '0;
    ti = '0;
    for (int k = 0; k < NCH; k++) begin
      wv[k] = val_in[k];
      wi[k] = IW'(k);
    end
    for (int s = 0; s < NCH; s++) begin
      for (int j = s % 2; j < NCH - 1; j += 2) begin
        if ((wv[j] > wv[j+1]) || ((wv[j] == wv[j+1]) && (wi[j] > wi[j+1]))) begin
          tv = wv[j]; wv[j] = wv[j+1]; wv[j+1] = tv;
          ti = wi[j]; wi[j] = wi[j+1]; wi[j+1] = ti;
        end
      end
    end
    for (int k = 0; k < NCH; k++) begin
      val_out[k] = wv[k];
      idx_out[k] = wi[k];
    end
  end
endmodule

// File: rtl/skew_adjust.sv
// Neighbour gaps, suffix accumulation toward the reference, halving and
// scatter back to originating channels.
module skew_adjust #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [DW-1:0] srt_val [NCH],
  input  logic [IW-1:0] srt_idx [NCH],
  output logic [DW-1:0] adj_ch  [NCH],
  output logic [IW-1:0] ref_idx
);
  logic [DW-1:0] gap  [NCH];
  logic [DW-1:0] acc  [NCH];
  logic [DW-1:0] half [NCH];

  // gap[k] = distance from sorted position k to k+1; top slot has none
  for (genvar k = 0; k < NCH; k++) begin : g_gap
    if (k == NCH - 1) begin : g_top
      assign gap[k] = '0;
      assign acc[k] = '0;
    end else begin : g_mid
      assign gap[k] = srt_val[k+1] - srt_val[k];
      assign acc[k] = acc[k+1] + gap[k];
    end
    assign half[k] = acc[k] >> 1;
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) adj_ch[c] = '0;
    for (int k = 0; k < NCH; k++) adj_ch[srt_idx[k]] = half[k];
  end

  assign ref_idx = srt_idx[NCH-1];
endmodule

// File: rtl/skew_comp_top.sv
module skew_comp_top #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NCH*DW-1:0] rtt_in,
  output logic              busy,
  output logic              done,
  output logic [NCH*DW-1:0] adj_out,
  output logic [IW-1:0]     ref_ch
);
  import skew_pkg::*;

  ctl_state_t    state;
  logic [DW-1:0] in_v   [NCH];
  logic [DW-1:0] cap_v  [NCH];
  logic [DW-1:0] net_v  [NCH];
  logic [IW-1:0] net_i  [NCH];
  logic [DW-1:0] srt_v  [NCH];
  logic [IW-1:0] srt_i  [NCH];
  logic [DW-1:0] calc_a [NCH];
  logic [IW-1:0] calc_r;
  logic [DW-1:0] adj_q  [NCH];
  logic [IW-1:0] ref_q;
  logic          done_q;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    assign in_v[c] = rtt_in[c*DW +: DW];
    assign adj_out[c*DW +: DW] = adj_q[c];
  end

  skew_sorter #(.NCH(NCH), .DW(DW)) u_sort (
    .val_in (cap_v),
    .val_out(net_v),
    .idx_out(net_i)
  );

  skew_adjust #(.NCH(NCH), .DW(DW)) u_adj (
    .srt_val(srt_v),
    .srt_idx(srt_i),
    .adj_ch (calc_a),
    .ref_idx(calc_r)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done_q <= 1'b0;
      ref_q  <= '0;
      for (int c = 0; c < NCH; c++) begin
        cap_v[c] <= '0;
        srt_v[c] <= '0;
        srt_i[c] <= '0;
        adj_q[c] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          for (int c = 0; c < NCH; c++) cap_v[c] <= in_v[c];
          state <= ST_SORT;
        end
        ST_SORT: begin
          for (int c = 0; c < NCH; c++) begin
            srt_v[c] <= net_v[c];
            srt_i[c] <= net_i[c];
          end
          state <= ST_CALC;
        end
        ST_CALC: begin
          for (int c = 0; c < NCH; c++) adj_q[c] <= calc_a[c];
          ref_q  <= calc_r;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign done   = done_q;
  assign ref_ch = ref_q;

  // ---------------- assertions ----------------
  assert_busy_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> (state != ST_SORT));
  assert_ref_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (adj_q[ref_q] == '0));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $past(rst_n)) |-> ($stable(adj_out) && $stable(ref_ch)));

  for (genvar k = 0; k < NCH - 1; k++) begin : g_chk_sort
    assert_sort_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CALC) |-> (srt_v[k] <= srt_v[k+1]));
  end

  for (genvar a = 0; a < NCH; a++) begin : g_chk_a
    assert_lane_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (adj_q[a] == DW'((cap_v[ref_q] - cap_v[a]) >> 1)));
    for (genvar b = a + 1; b < NCH; b++) begin : g_chk_b
      assert_tie_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (cap_v[a] == cap_v[b])) |-> (adj_q[a] == adj_q[b]));
    end
  end
endmodule

// File: tb/test_skew_comp_top.sv
module test_skew_comp_top;
  localparam int NCH = 4;
  localparam int DW  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [NCH*DW-1:0] rtt_in = '0;
  logic              busy, done;
  logic [NCH*DW-1:0] adj_out;
  logic [1:0]        ref_ch;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;  // 4 ns period

  skew_comp_top i_skew_comp_top (
    .clk(clk), .rst_n(rst_n), .start(start), .rtt_in(rtt_in),
    .busy(busy), .done(done), .adj_out(adj_out), .ref_ch(ref_ch)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lane(input int c);
    return int'(adj_out[c*DW +: DW]);
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_phase = 0, m_busy = 0, m_done = 0, m_ref = 0;
  int m_lat[NCH];
  int m_adj[NCH];

  initial for (int k = 0; k < NCH; k++) begin m_lat[k] = 0; m_adj[k] = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_busy = 0; m_done = 0; m_ref = 0;
      for (int k = 0; k < NCH; k++) m_adj[k] = 0;
    end else begin
      m_done = 0;
      if (m_phase == 0) begin
        if (start) begin
          for (int k = 0; k < NCH; k++) m_lat[k] = int'(rtt_in[k*DW +: DW]);
          m_phase = 1; m_busy = 1;
        end
      end else if (m_phase == 1) begin
        m_phase = 2;
      end else begin
        int mx;
        mx = -1;
        for (int k = 0; k < NCH; k++)
          if (m_lat[k] >= mx) begin mx = m_lat[k]; m_ref = k; end
        for (int k = 0; k < NCH; k++) m_adj[k] = (mx - m_lat[k]) / 2;
        m_done = 1; m_busy = 0; m_phase = 0;
      end
    end
  end

  always @(negedge clk) begin
    chk(busy == m_busy[0], "R3 busy", int'(busy), m_busy);
    chk(done == m_done[0], "R3 done", int'(done), m_done);
    chk(int'(ref_ch) == m_ref, "R6 ref_ch", int'(ref_ch), m_ref);
    for (int k = 0; k < NCH; k++)
      chk(lane(k) == m_adj[k], "R5 lane", lane(k), m_adj[k]);
  end

  // ---------------- stimulus ----------------
  function automatic logic [NCH*DW-1:0] pack4(input int a, input int b, input int c, input int d);
    return {DW'(d), DW'(c), DW'(b), DW'(a)};
  endfunction

  task automatic wait_done();
    int t;
    t = 0;
    while (!done && t < 20) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R3 done seen", int'(done), 1);
  endtask

  task automatic run(input int a, input int b, input int c, input int d);
    rtt_in = pack4(a, b, c, d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(adj_out == '0, "R1 adj_out", int'(adj_out[31:0]), 0);
    chk(ref_ch == 2'd0, "R1 ref_ch", int'(ref_ch), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2/R4: start, then disturb inputs and pulse start while busy
    rtt_in = pack4(8, 5, 15, 13);
    start = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R3 busy after start", int'(busy), 1);
    rtt_in = pack4(1000, 2, 3, 4);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(lane(0) == 3, "R2 R8 ch0", lane(0), 3);
    chk(lane(1) == 5, "R4 R8 ch1", lane(1), 5);
    chk(lane(2) == 0, "R6 ch2 reference", lane(2), 0);
    chk(lane(3) == 1, "R5 ch3 truncated", lane(3), 1);
    chk(ref_ch == 2'd2, "R6 ref index", int'(ref_ch), 2);

    // R9: outputs hold while inputs move
    begin
      logic [NCH*DW-1:0] snap;
      snap = adj_out;
      for (int i = 0; i < 5; i++) begin
        rtt_in = pack4(i, 7 * i, 300, i + 9);
        @(negedge clk);
        chk(adj_out == snap, "R9 hold", int'(adj_out[15:0]), int'(snap[15:0]));
      end
    end

    // R7/R6: ties at the maximum and elsewhere
    run(100, 200, 200, 50);
    chk(lane(1) == lane(2), "R7 tie lanes", lane(1), lane(2));
    chk(ref_ch == 2'd2, "R6 tie reference", int'(ref_ch), 2);
    chk(lane(3) == 75, "R5 ch3", lane(3), 75);

    run(7, 7, 7, 7);
    chk(adj_out == '0, "R7 all equal", lane(0), 0);
    chk(ref_ch == 2'd3, "R6 all equal ref", int'(ref_ch), 3);

    // R10: extremes
    run(0, 65535, 1, 65535);
    chk(lane(0) == 32767, "R10 ch0", lane(0), 32767);
    chk(lane(2) == 32767, "R10 ch2", lane(2), 32767);
    chk(ref_ch == 2'd3, "R10 ref", int'(ref_ch), 3);

    // R5: odd difference truncation, R8 reference not at top lane
    run(10, 13, 10, 10);
    chk(lane(0) == 1, "R5 odd gap", lane(0), 1);
    chk(ref_ch == 2'd1, "R8 ref ch1", int'(ref_ch), 1);

    // random sweep, compared each cycle by the model
    for (int r = 0; r < 40; r++)
      run(int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
          int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)));

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule